// File: doc/BRIEF.md
# Instruction Translation Cache with Recency-Ordered Refill

This block is a four-slot, fully associative translation cache for instruction fetches. A fetch lookup presents a virtual address and an address-space identifier. When a slot matches, the block returns the physical address and protection bits one clock later, and it records that slot as the most recently used. The recency state is a 6-bit pairwise-order field held in the top six bits of a shared 32-bit MMU control register. The remaining 26 bits of that register belong to other functions, and the block never alters them.

When no slot matches, the block stalls new lookups and sends the address to a larger unified translation table through a simple request/response interface. A single unified match is copied into the slot that the recency field names as least recently used. That slot is then returned as the result, and it is marked most recently used. A unified "no match" answer is converted into an instruction-side miss code. A unified "multiple match" answer is passed through unchanged, and nothing in the cache is modified for either failure.

Top module: `itlb_refill`

## Requirements
- R1: After reset every slot is invalid, `ctl_q` is 0, `req_ready` is 1, and `rsp_valid` and `utlb_req` are 0.
- R2: A valid slot matches when the address agrees with `vpn<<10` above the page offset and the slot is shared or its ASID equals `req_asid`. The size codes 0, 1, 2 and 3 give offset widths of 10, 12, 16 and 20 bits. On a match the response follows one clock later with status 0, the slot index, `paddr = (ppn<<10 with the offset cleared) | offset of the address`, and the slot's protection bits. If several slots match, the lowest index wins.
- R3: In the recency field f = `ctl_q[31:26]`, a result on slot 0 clears bits 31:29. Slot 1 sets bit 31 and clears bits 28:27. Slot 2 sets bits 30 and 28 and clears bit 26. Slot 3 sets bits 29, 27 and 26.
- R4: The victim slot is decoded in priority order: slot 0 if bits 31:29 are all 1; otherwise slot 1 if bit 31 is 0 and bits 28:27 are both 1; otherwise slot 2 if bits 30 and 28 are 0 and bit 26 is 1; otherwise slot 3.
- R5: On a miss, `utlb_req` rises with the latched address and ASID. In the clock where `utlb_rsp_valid` is seen with status 0, the unified entry is written into the victim slot. The response (status 0, victim slot) and the recency update appear after that same edge, and later lookups hit the copied entry.
- R6: A unified status of 1 (no match) is reported as status 3 (instruction miss). Status 1 never appears on `rsp_status`, and neither the slots nor `ctl_q` change.
- R7: A unified status of 2 (multiple match) is reported as status 2, and neither the slots nor `ctl_q` change.
- R8: The block never changes `ctl_q[25:0]`. `ctl_wr` loads all 32 bits of `ctl_wdata`, and it overrides a recency update on the same edge.
- R9: `req_ready` is 0 from the edge that accepts a missing lookup until the edge that returns its response. A `req_valid` presented while `req_ready` is 0 produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Block can accept a lookup |
| req_va | input | 32 | Virtual fetch address |
| req_asid | input | 8 | Current address-space identifier |
| rsp_valid | output | 1 | Result valid for one clock |
| rsp_status | output | 2 | 0 ok, 2 multiple match, 3 instruction miss |
| rsp_slot | output | 2 | Slot that produced the result |
| rsp_paddr | output | 29 | Physical address |
| rsp_prot | output | 2 | Protection bits of the entry |
| utlb_req | output | 1 | Unified lookup pending |
| utlb_va | output | 32 | Address sent to the unified table |
| utlb_asid | output | 8 | ASID sent to the unified table |
| utlb_rsp_valid | input | 1 | Unified answer valid |
| utlb_rsp_status | input | 2 | 0 hit, 1 no match, 2 multiple match |
| utlb_ent_valid | input | 1 | Unified entry valid bit |
| utlb_ent_shared | input | 1 | Unified entry ignores ASID |
| utlb_ent_asid | input | 8 | Unified entry ASID |
| utlb_ent_vpn | input | 22 | Unified entry virtual page number |
| utlb_ent_size | input | 2 | Unified entry size code |
| utlb_ent_ppn | input | 19 | Unified entry physical page number |
| utlb_ent_prot | input | 2 | Unified entry protection bits |
| ctl_wr | input | 1 | Write of the shared control register |
| ctl_wdata | input | 32 | Control register write value |
| ctl_q | output | 32 | Control register contents |

## Verification
The lookups cover all four page sizes and both shared and private ASIDs. Repeated hits to one slot separate the hit path from a refill, and a chain of refills walks the victim decode through every slot, which shows whether each recency pattern selects the right victim. An ASID mismatch and an address one byte past a page end show that matching uses both the ASID and the size-dependent offset width. Overlapping unified entries produce the multiple-match code, and two overlapping cached entries expose the lowest-index priority. A control write on the same edge as a hit, and a request held during a stall, test write priority and that a request during a stall is dropped.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  localparam int VA_W   = 32;
  localparam int ASID_W = 8;
  localparam int PG_MIN = 10;
  localparam int VPN_W  = VA_W - PG_MIN;
  localparam int PPN_W  = 19;
  localparam int PA_W   = PPN_W + PG_MIN;
  localparam int PROT_W = 2;
  localparam int N_SLOT = 4;
  localparam int SLOT_W = $clog2(N_SLOT);
  localparam int CTL_W  = 32;
  localparam int LRU_W  = 6;
  localparam int LRU_LO = CTL_W - LRU_W;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_DMISS = 2'd1,
    ST_MULTI = 2'd2,
    ST_IMISS = 2'd3
  } status_e;

  typedef struct packed {
    logic              valid;
    logic              shared;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [1:0]        size;
    logic [PPN_W-1:0]  ppn;
    logic [PROT_W-1:0] prot;
  } entry_t;

  // Offset mask for the four page sizes: 1K, 4K, 64K, 1M.
  function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
    logic [VA_W-1:0] m;
    case (sz)
      2'd0:    m = 32'h0000_03FF;
      2'd1:    m = 32'h0000_0FFF;
      2'd2:    m = 32'h0000_FFFF;
      default: m = 32'h000F_FFFF;
    endcase
    return m;
  endfunction

  function automatic logic entry_hits(input entry_t e, input logic [VA_W-1:0] va,
                                      input logic [ASID_W-1:0] asid);
    logic [VA_W-1:0] base;
    base = {e.vpn, {PG_MIN{1'b0}}};
    return e.valid && (((va ^ base) & ~page_mask(e.size)) == '0) &&
           (e.shared || (e.asid == asid));
  endfunction

  function automatic logic [PA_W-1:0] phys_addr(input entry_t e, input logic [VA_W-1:0] va);
    logic [VA_W-1:0] m;
    logic [PA_W-1:0] pm;
    m  = page_mask(e.size);
    pm = m[PA_W-1:0];
    return ({e.ppn, {PG_MIN{1'b0}}} & ~pm) | (va[PA_W-1:0] & pm);
  endfunction

  // Pairwise recency: field bit 5 is control bit 31.
  function automatic logic [LRU_W-1:0] lru_touch(input logic [LRU_W-1:0] f,
                                                 input logic [SLOT_W-1:0] s);
    logic [LRU_W-1:0] n;
    n = f;
    case (s)
      2'd0: n[5:3] = 3'b000;
      2'd1: begin n[5] = 1'b1; n[2:1] = 2'b00; end
      2'd2: begin n[4] = 1'b1; n[2] = 1'b1; n[0] = 1'b0; end
      default: begin n[3] = 1'b1; n[1] = 1'b1; n[0] = 1'b1; end
    endcase
    return n;
  endfunction

  function automatic logic [SLOT_W-1:0] lru_victim(input logic [LRU_W-1:0] f);
    if (f[5:3] == 3'b111)                      return 2'd0;
    if (!f[5] && (f[2:1] == 2'b11))            return 2'd1;
    if (!f[4] && !f[2] && f[0])                return 2'd2;
    return 2'd3;
  endfunction

  function automatic status_e status_xlate(input status_e st);
    return (st == ST_DMISS) ? ST_IMISS : st;
  endfunction
endpackage

// File: rtl/itlb_lru.sv
module itlb_lru
  import itlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [CTL_W-1:0]  sw_data,
  input  logic              touch_en,
  input  logic [SLOT_W-1:0] touch_slot,
  output logic [CTL_W-1:0]  ctl,
  output logic [SLOT_W-1:0] victim
);
  logic [CTL_W-1:0] ctl_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_r <= '0;
    end else if (sw_wr) begin
      ctl_r <= sw_data;
    end else if (touch_en) begin
      ctl_r[CTL_W-1:LRU_LO] <= lru_touch(ctl_r[CTL_W-1:LRU_LO], touch_slot);
    end
  end

  assign ctl    = ctl_r;
  assign victim = lru_victim(ctl_r[CTL_W-1:LRU_LO]);
endmodule

// File: rtl/itlb_array.sv
module itlb_array
  import itlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  entry_t            wr_entry,
  input  logic [VA_W-1:0]   look_va,
  input  logic [ASID_W-1:0] look_asid,
  output logic              hit,
  output logic [SLOT_W-1:0] hit_slot,
  output entry_t            hit_entry
);
  entry_t            ent [N_SLOT];
  logic [N_SLOT-1:0] match_vec;

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    entry_t ent_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (wr_en && (wr_slot == SLOT_W'(g))) begin
        ent_q <= wr_entry;
      end
    end
    assign ent[g]       = ent_q;
    assign match_vec[g] = entry_hits(ent_q, look_va, look_asid);
  end

  always_comb begin
    hit_slot = '0;
    for (int i = N_SLOT - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_slot = SLOT_W'(i);
    end
  end

  assign hit       = |match_vec;
  assign hit_entry = ent[hit_slot];
endmodule

// File: rtl/itlb_ctrl.sv
module itlb_ctrl
  import itlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  input  logic [ASID_W-1:0] req_asid,
  output logic              req_ready,
  input  logic              arr_hit,
  input  logic [SLOT_W-1:0] arr_slot,
  input  entry_t            arr_entry,
  input  logic [SLOT_W-1:0] victim,
  output logic              utlb_req,
  output logic [VA_W-1:0]   utlb_va,
  output logic [ASID_W-1:0] utlb_asid,
  input  logic              utlb_rsp_valid,
  input  status_e           utlb_status,
  input  entry_t            utlb_entry,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_slot,
  output entry_t            wr_entry,
  output logic              touch_en,
  output logic [SLOT_W-1:0] touch_slot,
  output logic              miss_fire,
  output logic              refill_fire,
  output logic              rsp_valid,
  output status_e           rsp_status,
  output logic [SLOT_W-1:0] rsp_slot,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [PROT_W-1:0] rsp_prot
);
  typedef enum logic {S_IDLE, S_WAIT} state_e;

  state_e            state;
  logic [VA_W-1:0]   va_q;
  logic [ASID_W-1:0] asid_q;
  logic              accept, hit_fire, fail_fire, got_rsp;

  assign accept      = (state == S_IDLE) && req_valid;
  assign hit_fire    = accept && arr_hit;
  assign miss_fire   = accept && !arr_hit;
  assign got_rsp     = (state == S_WAIT) && utlb_rsp_valid;
  assign refill_fire = got_rsp && (utlb_status == ST_OK);
  assign fail_fire   = got_rsp && (utlb_status != ST_OK);

  assign req_ready  = (state == S_IDLE);
  assign utlb_req   = (state == S_WAIT);
  assign utlb_va    = va_q;
  assign utlb_asid  = asid_q;

  assign wr_en      = refill_fire;
  assign wr_slot    = victim;
  assign wr_entry   = utlb_entry;
  assign touch_en   = hit_fire || refill_fire;
  assign touch_slot = hit_fire ? arr_slot : victim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      va_q   <= '0;
      asid_q <= '0;
    end else begin
      if (miss_fire) begin
        state  <= S_WAIT;
        va_q   <= req_va;
        asid_q <= req_asid;
      end else if (got_rsp) begin
        state <= S_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_slot   <= '0;
      rsp_paddr  <= '0;
      rsp_prot   <= '0;
    end else begin
      rsp_valid <= hit_fire || got_rsp;
      if (hit_fire) begin
        rsp_status <= ST_OK;
        rsp_slot   <= arr_slot;
        rsp_paddr  <= phys_addr(arr_entry, req_va);
        rsp_prot   <= arr_entry.prot;
      end else if (refill_fire) begin
        rsp_status <= ST_OK;
        rsp_slot   <= victim;
        rsp_paddr  <= phys_addr(utlb_entry, va_q);
        rsp_prot   <= utlb_entry.prot;
      end else if (fail_fire) begin
        rsp_status <= status_xlate(utlb_status);
        rsp_slot   <= '0;
        rsp_paddr  <= '0;
        rsp_prot   <= '0;
      end
    end
  end
endmodule

// File: rtl/itlb_refill.sv
module itlb_refill
  import itlb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [31:0]        req_va,
  input  logic [7:0]         req_asid,
  output logic               rsp_valid,
  output logic [1:0]         rsp_status,
  output logic [1:0]         rsp_slot,
  output logic [28:0]        rsp_paddr,
  output logic [1:0]         rsp_prot,
  output logic               utlb_req,
  output logic [31:0]        utlb_va,
  output logic [7:0]         utlb_asid,
  input  logic               utlb_rsp_valid,
  input  logic [1:0]         utlb_rsp_status,
  input  logic               utlb_ent_valid,
  input  logic               utlb_ent_shared,
  input  logic [7:0]         utlb_ent_asid,
  input  logic [21:0]        utlb_ent_vpn,
  input  logic [1:0]         utlb_ent_size,
  input  logic [18:0]        utlb_ent_ppn,
  input  logic [1:0]         utlb_ent_prot,
  input  logic               ctl_wr,
  input  logic [31:0]        ctl_wdata,
  output logic [31:0]        ctl_q
);
  entry_t            utlb_entry, arr_entry, wr_entry;
  logic              arr_hit, wr_en, touch_en;
  logic [SLOT_W-1:0] arr_slot, victim, wr_slot, touch_slot;
  logic              miss_fire, refill_fire;
  status_e           rsp_status_e;

  assign utlb_entry = '{valid: utlb_ent_valid, shared: utlb_ent_shared, asid: utlb_ent_asid,
                        vpn: utlb_ent_vpn, size: utlb_ent_size, ppn: utlb_ent_ppn,
                        prot: utlb_ent_prot};

  itlb_array u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_entry(wr_entry),
    .look_va(req_va), .look_asid(req_asid),
    .hit(arr_hit), .hit_slot(arr_slot), .hit_entry(arr_entry)
  );

  itlb_lru u_lru (
    .clk(clk), .rst_n(rst_n),
    .sw_wr(ctl_wr), .sw_data(ctl_wdata),
    .touch_en(touch_en), .touch_slot(touch_slot),
    .ctl(ctl_q), .victim(victim)
  );

  itlb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_va(req_va), .req_asid(req_asid), .req_ready(req_ready),
    .arr_hit(arr_hit), .arr_slot(arr_slot), .arr_entry(arr_entry), .victim(victim),
    .utlb_req(utlb_req), .utlb_va(utlb_va), .utlb_asid(utlb_asid),
    .utlb_rsp_valid(utlb_rsp_valid), .utlb_status(status_e'(utlb_rsp_status)),
    .utlb_entry(utlb_entry),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_entry(wr_entry),
    .touch_en(touch_en), .touch_slot(touch_slot),
    .miss_fire(miss_fire), .refill_fire(refill_fire),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status_e), .rsp_slot(rsp_slot),
    .rsp_paddr(rsp_paddr), .rsp_prot(rsp_prot)
  );

  assign rsp_status = rsp_status_e;
endmodule

// File: rtl/itlb_refill_chk.sv
module itlb_refill_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        utlb_req,
  input logic        utlb_rsp_valid,
  input logic [1:0]  utlb_rsp_status,
  input logic        rsp_valid,
  input logic [1:0]  rsp_status,
  input logic [1:0]  rsp_slot,
  input logic        ctl_wr,
  input logic [31:0] ctl_q,
  input logic        miss_fire,
  input logic        refill_fire,
  input logic [1:0]  victim
);
  a_r8_low_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(ctl_q[25:0]));

  a_r6_no_data_miss_code: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status != 2'd1));

  a_r5_refill_returns_victim: assert property (@(posedge clk) disable iff (!rst_n)
    refill_fire |=> (rsp_valid && (rsp_status == 2'd0) && (rsp_slot == $past(victim))));

  a_r3_slot0_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_status == 2'd0) && (rsp_slot == 2'd0) && !$past(ctl_wr))
      |-> (ctl_q[31:29] == 3'b000));

  a_r3_slot3_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_status == 2'd0) && (rsp_slot == 2'd3) && !$past(ctl_wr))
      |-> (ctl_q[29] && ctl_q[27] && ctl_q[26]));

  a_r9_stall_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fire |=> !req_ready);

  a_r9_utlb_only_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    utlb_req |-> !req_ready);

  a_r7_fail_keeps_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    (utlb_req && utlb_rsp_valid && (utlb_rsp_status != 2'd0) && !ctl_wr) |=> $stable(ctl_q));
endmodule

bind itlb_refill itlb_refill_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .utlb_req(utlb_req),
  .utlb_rsp_valid(utlb_rsp_valid), .utlb_rsp_status(utlb_rsp_status),
  .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_slot(rsp_slot),
  .ctl_wr(ctl_wr), .ctl_q(ctl_q), .miss_fire(miss_fire), .refill_fire(refill_fire),
  .victim(victim)
);

// File: tb/itlb_refill_bench.sv
module itlb_refill_bench;
  import itlb_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [7:0]  req_asid = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_status, rsp_slot, rsp_prot;
  logic [28:0] rsp_paddr;
  logic        utlb_req;
  logic [31:0] utlb_va;
  logic [7:0]  utlb_asid;
  logic        utlb_rsp_valid = 1'b0;
  logic [1:0]  utlb_rsp_status = '0;
  entry_t      u_ent = '0;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  itlb_refill u_itlb_refill (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_asid(req_asid), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_slot(rsp_slot), .rsp_paddr(rsp_paddr), .rsp_prot(rsp_prot),
    .utlb_req(utlb_req), .utlb_va(utlb_va), .utlb_asid(utlb_asid),
    .utlb_rsp_valid(utlb_rsp_valid), .utlb_rsp_status(utlb_rsp_status),
    .utlb_ent_valid(u_ent.valid), .utlb_ent_shared(u_ent.shared), .utlb_ent_asid(u_ent.asid),
    .utlb_ent_vpn(u_ent.vpn), .utlb_ent_size(u_ent.size), .utlb_ent_ppn(u_ent.ppn),
    .utlb_ent_prot(u_ent.prot), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- bench-side reference model ----------------
  entry_t m_itlb [4];
  entry_t m_utlb [8];
  int     order[$];          // slot indices, most recent first
  logic [25:0] m_low = '0;

  function automatic longint unsigned pg_bytes(input logic [1:0] sz);
    case (sz)
      2'd0: return 64'd1024;
      2'd1: return 64'd4096;
      2'd2: return 64'd65536;
      default: return 64'd1048576;
    endcase
  endfunction

  function automatic bit m_hit(input entry_t e, input logic [31:0] va, input logic [7:0] asid);
    longint unsigned b, base, v;
    if (!e.valid) return 0;
    if (!(e.shared || e.asid == asid)) return 0;
    b = pg_bytes(e.size);
    base = 64'(e.vpn) * 1024;
    v = 64'(va);
    return (v / b) == (base / b);
  endfunction

  function automatic logic [28:0] m_pa(input entry_t e, input logic [31:0] va);
    longint unsigned b, p;
    b = pg_bytes(e.size);
    p = ((64'(e.ppn) * 1024) / b) * b + (64'(va) % b);
    return p[28:0];
  endfunction

  function automatic int pos(input int s);
    foreach (order[i]) if (order[i] == s) return i;
    return 99;
  endfunction

  function automatic logic [5:0] m_field();
    logic [5:0] f;
    f[5] = pos(1) < pos(0);
    f[4] = pos(2) < pos(0);
    f[3] = pos(3) < pos(0);
    f[2] = pos(2) < pos(1);
    f[1] = pos(3) < pos(1);
    f[0] = pos(3) < pos(2);
    return f;
  endfunction

  task automatic m_use(input int s);
    int p;
    p = pos(s);
    order.delete(p);
    order.push_front(s);
  endtask

  function automatic entry_t mk(input logic [31:0] va, input logic [1:0] sz, input logic [7:0] asid,
                                input bit shared, input logic [31:0] pa, input logic [1:0] prot);
    entry_t e;
    e.valid = 1'b1; e.shared = shared; e.asid = asid; e.vpn = va[31:10];
    e.size = sz; e.ppn = pa[28:10]; e.prot = prot;
    return e;
  endfunction

  typedef struct {
    logic [1:0]  st;
    logic [1:0]  slot;
    logic [28:0] pa;
    logic [1:0]  prot;
    logic [31:0] ctl;
    string       tag;
  } exp_t;
  exp_t sb[$];
  logic [31:0] last_va;

  task automatic predict(input logic [31:0] va, input logic [7:0] asid, input string tag,
                         input bit wr, input logic [31:0] wd);
    exp_t it;
    int hs, n, idx, v;
    hs = -1; n = 0; idx = 0;
    it.tag = tag; it.slot = '0; it.pa = '0; it.prot = '0;
    for (int i = 0; i < 4; i++) if (hs < 0 && m_hit(m_itlb[i], va, asid)) hs = i;
    if (hs >= 0) begin
      it.st = 2'd0; it.slot = 2'(hs); it.pa = m_pa(m_itlb[hs], va); it.prot = m_itlb[hs].prot;
      m_use(hs);
    end else begin
      for (int i = 0; i < 8; i++) if (m_hit(m_utlb[i], va, asid)) begin n++; idx = i; end
      if (n == 1) begin
        v = order[order.size()-1];
        m_itlb[v] = m_utlb[idx];
        it.st = 2'd0; it.slot = 2'(v); it.pa = m_pa(m_utlb[idx], va); it.prot = m_utlb[idx].prot;
        m_use(v);
      end else begin
        it.st = (n == 0) ? 2'd3 : 2'd2;
      end
    end
    if (wr) begin
      order = '{0, 1, 2, 3};   // written value carries zero recency bits
      m_low = wd[25:0];
    end
    it.ctl = {m_field(), m_low};
    sb.push_back(it);
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    predict(va, asid, tag, 1'b0, '0);
    last_va = va;
    req_valid = 1'b1; req_va = va; req_asid = asid;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic lookup_wr(input logic [31:0] va, input logic [7:0] asid, input logic [31:0] wd,
                           input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    predict(va, asid, tag, 1'b1, wd);
    req_valid = 1'b1; req_va = va; req_asid = asid;
    ctl_wr = 1'b1; ctl_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; ctl_wr = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0 || !req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // ---------------- unified table responder ----------------
  initial begin
    int cnt, n, idx;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (utlb_rsp_valid) begin
        utlb_rsp_valid = 1'b0;
      end else if (utlb_req) begin
        if (cnt == 2) begin
          n = 0; idx = 0;
          for (int i = 0; i < 8; i++) if (m_hit(m_utlb[i], utlb_va, utlb_asid)) begin n++; idx = i; end
          check(utlb_va == last_va, "R5", "unified request address", 64'(utlb_va), 64'(last_va));
          utlb_rsp_status = (n == 1) ? 2'd0 : (n == 0) ? 2'd1 : 2'd2;
          u_ent = (n == 1) ? m_utlb[idx] : '0;
          utlb_rsp_valid = 1'b1;
          cnt = 0;
        end else begin
          cnt++;
        end
      end
    end
  end

  // ---------------- scoreboard monitor ----------------
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rsp_valid && rst_n) begin
        if (sb.size() == 0) begin
          check(1'b0, "R9", "unexpected response", 64'(rsp_status), 64'hFF);
        end else begin
          e = sb.pop_front();
          check(rsp_status == e.st, e.tag, "status", 64'(rsp_status), 64'(e.st));
          if (e.st == 2'd0) begin
            check(rsp_slot == e.slot, e.tag, "slot", 64'(rsp_slot), 64'(e.slot));
            check(rsp_paddr == e.pa, e.tag, "paddr", 64'(rsp_paddr), 64'(e.pa));
            check(rsp_prot == e.prot, e.tag, "prot", 64'(rsp_prot), 64'(e.prot));
          end
          check(ctl_q == e.ctl, e.tag, "ctl", 64'(ctl_q), 64'(e.ctl));
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    for (int i = 0; i < 4; i++) m_itlb[i] = '0;
    for (int i = 0; i < 8; i++) m_utlb[i] = '0;
    order = '{0, 1, 2, 3};
    last_va = '0;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
    check(rsp_valid == 1'b0, "R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    check(utlb_req == 1'b0, "R1", "utlb_req", 64'(utlb_req), 64'd0);
    check(ctl_q == 32'd0, "R1", "ctl_q", 64'(ctl_q), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 software write with zero recency bits, low bits preserved afterwards
    ctl_wr = 1'b1; ctl_wdata = 32'h0155_AA55;
    @(negedge clk);
    ctl_wr = 1'b0;
    m_low = 26'h155_AA55;
    check(ctl_q == 32'h0155_AA55, "R8", "written ctl", 64'(ctl_q), 64'h0155_AA55);

    m_utlb[0] = mk(32'h0001_0000, 2'd1, 8'd5, 1'b0, 32'h0A00_0000, 2'd1); // 4K
    m_utlb[1] = mk(32'h0002_0400, 2'd0, 8'd5, 1'b0, 32'h0B00_0400, 2'd2); // 1K
    m_utlb[2] = mk(32'h0030_0000, 2'd2, 8'd1, 1'b1, 32'h0C03_0000, 2'd3); // 64K shared
    m_utlb[3] = mk(32'h0100_0000, 2'd3, 8'd7, 1'b0, 32'h0D10_0000, 2'd0); // 1M
    m_utlb[4] = mk(32'h0004_0000, 2'd1, 8'd5, 1'b0, 32'h0E00_4000, 2'd1); // 4K
    m_utlb[5] = mk(32'h0050_0000, 2'd1, 8'd5, 1'b0, 32'h0F00_0000, 2'd1); // overlap pair
    m_utlb[6] = mk(32'h0050_0000, 2'd2, 8'd5, 1'b0, 32'h0F10_0000, 2'd2);

    // R5 R4 refill chain walks victims 3,2,1,0
    lookup(32'h0001_0123, 8'd5, "R5");
    drain();
    lookup(32'h0001_0FFC, 8'd5, "R2");          // hit, 4K offset
    lookup(32'h0002_07F0, 8'd5, "R4");
    drain();
    lookup(32'h0030_ABCD, 8'd9, "R4");          // shared entry, other ASID
    drain();
    lookup(32'h010F_F004, 8'd7, "R3");          // 1M page into slot 0
    drain();
    lookup(32'h0001_0200, 8'd5, "R3");          // hit slot 3
    lookup(32'h0004_0010, 8'd5, "R4");
    drain();
    lookup(32'h0002_0404, 8'd5, "R4");
    drain();
    // R6 ASID mismatch and one byte past page end
    lookup(32'h0001_0004, 8'd6, "R6");
    drain();
    lookup(32'h0001_1000, 8'd5, "R6");
    drain();
    // R7 overlapping unified entries
    lookup(32'h0050_0100, 8'd5, "R7");
    drain();
    // R2 hits after failures
    lookup(32'h0030_0008, 8'd2, "R2");
    lookup(32'h0100_0044, 8'd7, "R2");
    drain();

    // R2 lowest index wins among overlapping cached entries
    for (int i = 0; i < 8; i++) m_utlb[i] = '0;
    m_utlb[0] = mk(32'h0200_0000, 2'd1, 8'd5, 1'b0, 32'h1100_0000, 2'd1);
    lookup(32'h0200_0010, 8'd5, "R2");
    drain();
    m_utlb[0] = mk(32'h0200_0000, 2'd3, 8'd5, 1'b0, 32'h1200_0000, 2'd3);
    lookup(32'h0208_0010, 8'd5, "R2");
    drain();
    lookup(32'h0200_0020, 8'd5, "R2");
    drain();

    // R9 request held during a stall produces no response
    m_utlb[1] = mk(32'h0060_0000, 2'd1, 8'd5, 1'b0, 32'h1300_0000, 2'd2);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    predict(32'h0060_0040, 8'd5, "R9", 1'b0, '0);
    last_va = 32'h0060_0040;
    req_valid = 1'b1; req_va = 32'h0060_0040; req_asid = 8'd5;
    @(negedge clk);
    req_va = 32'h0200_0030;                     // would hit if accepted
    check(req_ready == 1'b0, "R9", "stall after miss", 64'(req_ready), 64'd0);
    @(negedge clk);
    check(req_ready == 1'b0, "R9", "stall held", 64'(req_ready), 64'd0);
    req_valid = 1'b0;
    drain();
    check(sb.size() == 0, "R9", "scoreboard empty", 64'(sb.size()), 64'd0);

    // R8 write wins over a hit touch on the same edge
    lookup_wr(32'h0060_0044, 8'd5, 32'h0000_1234, "R8");
    drain();
    lookup(32'h0060_0048, 8'd5, "R3");
    drain();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule